// File: doc/BRIEF.md
# Sample Clock Divider with Phase Slip

This block takes a converter's input sample clock and produces a divided clock at one, one half or one quarter of the input rate. It also produces a clock-enable strobe that marks the first input cycle of every divided period. Logic that stays on the fast clock uses the strobe, and logic that needs a real slower clock uses the divided clock.

The divisor is held in a three-bit field that is written through a plain register-write port. When that field holds the pin-control code, or any code that is not defined, the divisor comes from a decoded three-level strap input instead. A new divisor is not applied at once. It is picked up at the next boundary of the divided period, so the output never carries a shortened pulse.

A second register address carries a one-shot phase-slip command. Writing it makes one divided period exactly one input cycle shorter, which moves the next divided rising edge one input cycle earlier. The command then clears itself. Repeated slips let several converters be brought into the same divided phase. A soft reset restarts the divider phase and drops a pending slip, but it keeps the divisor field. A full reset clears everything.

Top module: `sample_clk_divider`

## Requirements
- R1: Field codes 001, 010 and 100, written to address 2 in `wr_data[2:0]`, select divide by 1, 2 and 4. `div_ce` is high in exactly one input cycle out of every N, namely the first cycle of each divided period. For N of 2 or 4, `div_clk` is high for the first N/2 input cycles of each period. For N of 1, `div_clk` follows the input clock.
- R2: Code 000, and the undefined codes 011, 101, 110 and 111, hand the divisor over to the strap input.
- R3: Under strap control, strap code 00 selects divide by 1, 01 selects divide by 2, 10 selects divide by 4, and 11 falls back to divide by 1.
- R4: A change of divisor takes effect only at a period boundary. The period in progress finishes at its old length, and every later period has the new length.
- R5: Writing a 1 to bit 0 at address 1 while N is 2 or 4 shortens exactly one divided period to N-1 input cycles.
- R6: The slip command clears itself once it has been applied. The periods that follow have full length until a new command is written.
- R7: With divide by 1 selected, a slip command changes nothing: `div_ce` stays high every cycle, and the command is dropped.
- R8: A soft reset restarts the period, so `div_ce` and `div_clk` are high in the first cycle after it. It keeps the divisor field, so a register-selected divisor survives it.
- R9: A full reset clears the divisor field to 000, which gives strap control, and holds the counter at zero, so `div_ce` is high during reset and in the first cycle after it. The first period after a full reset lasts one cycle, and then the selected divisor applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Full reset, asynchronous assert, active low |
| soft_rst | input | 1 | Synchronous soft reset; the divisor field is kept |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (2 = divisor field, 1 = slip command) |
| wr_data | input | DATA_W | Write data |
| strap | input | 2 | Decoded three-level strap code |
| div_clk | output | 1 | Divided clock |
| div_ce | output | 1 | Strobe in the first input cycle of each divided period |

## Verification
The assertions assume that the write port, the strap input and soft reset are all synchronous to `clk`, and that full reset is released away from a clock edge. The bench drives every input at the falling edge and only changes the strap code or the divisor when several full periods are left before the window it measures. Phase-slip and divisor-change windows start at a negedge on which `div_ce` is high, so the period in which the command lands is known exactly and the expected gap sequence can be worked out by arithmetic.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int LOG2_MAX = 2;
  localparam int CNT_W    = LOG2_MAX;
  localparam int CODE_W   = 3;
  localparam int STRAP_W  = 2;

  typedef enum logic [1:0] {DIV1 = 2'd0, DIV2 = 2'd1, DIV4 = 2'd2} div_sel_e;

  localparam logic [CODE_W-1:0] CODE_BY1 = 3'b001;
  localparam logic [CODE_W-1:0] CODE_BY2 = 3'b010;
  localparam logic [CODE_W-1:0] CODE_BY4 = 3'b100;

  // index of the final input cycle of a period
  function automatic logic [CNT_W-1:0] last_idx(div_sel_e d);
    logic [CNT_W:0] n;
    n = (CNT_W+1)'(1) << d;
    return CNT_W'(n - 1'b1);
  endfunction

  // index at which a pending slip ends the period one cycle early
  function automatic logic [CNT_W-1:0] slip_idx(div_sel_e d);
    logic [CNT_W:0] n;
    n = (CNT_W+1)'(1) << d;
    return (d == DIV1) ? '0 : CNT_W'(n - 2'd2);
  endfunction

  function automatic logic [CNT_W-1:0] half_len(div_sel_e d);
    return (d == DIV1) ? CNT_W'(1) : CNT_W'(1) << (d - 1'b1);
  endfunction

  function automatic div_sel_e strap_to_div(logic [STRAP_W-1:0] s);
    case (s)
      2'b01:   return DIV2;
      2'b10:   return DIV4;
      default: return DIV1;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 2,
  parameter logic [ADDR_W-1:0] SLIP_ADDR = 1,
  parameter int SLIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slip_ack,
  output logic [CODE_W-1:0] div_code,
  output logic              slip_pend
);
  logic wr_div, wr_slip;

  always_comb begin
    wr_div  = wr_en && (wr_addr == DIV_ADDR);
    wr_slip = wr_en && (wr_addr == SLIP_ADDR) && wr_data[SLIP_BIT];
  end

  // divisor field: only a full reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_code <= '0;
    else if (wr_div) div_code <= wr_data[CODE_W-1:0];
  end

  // one-shot slip command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slip_pend <= 1'b0;
    else if (soft_rst) slip_pend <= 1'b0;
    else if (wr_slip)  slip_pend <= 1'b1;
    else if (slip_ack) slip_pend <= 1'b0;
  end

  // R8: soft reset leaves the divisor field alone
  a_r8_soft_keeps_div: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_div) |=> (div_code == $past(div_code)));

  // R6: an acknowledged slip is gone next cycle unless re-armed
  a_r6_slip_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ack && !wr_slip) |=> !slip_pend);
endmodule

// File: rtl/clkdiv_select.sv
`timescale 1ns/1ps
module clkdiv_select
  import clkdiv_pkg::*;
(
  input  logic [CODE_W-1:0]  div_code,
  input  logic [STRAP_W-1:0] strap,
  output div_sel_e           sel
);
  always_comb begin
    case (div_code)
      CODE_BY1: sel = DIV1;
      CODE_BY2: sel = DIV2;
      CODE_BY4: sel = DIV4;
      default:  sel = strap_to_div(strap);
    endcase
  end
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  div_sel_e sel,
  input  logic     slip_pend,
  output logic     slip_ack,
  output logic     div_clk,
  output logic     div_ce
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  div_sel_e         cur_q;
  logic             at_wrap;

  always_comb begin
    slip_ack = slip_pend && (cnt_q == slip_idx(cur_q));
    at_wrap  = (cnt_q == last_idx(cur_q)) || slip_ack;
    cnt_d    = at_wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= DIV1;
    end else if (soft_rst) begin
      cnt_q <= '0;
      cur_q <= sel;
    end else begin
      cnt_q <= cnt_d;
      if (at_wrap) cur_q <= sel;
    end
  end

  assign div_ce  = (cnt_q == '0);
  assign div_clk = (cur_q == DIV1) ? clk : (cnt_q < half_len(cur_q));

  // R4: the active divisor only moves on a period boundary
  a_r4_div_changes_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> (cnt_q == '0));

  // R1: the phase counter stays inside the active period
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx(cur_q));

  // R5: an applied slip starts a new period on the next cycle
  a_r5_slip_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ack && !soft_rst) |=> div_ce);

  // R7: undivided mode strobes every cycle
  a_r7_div1_ce_always: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == DIV1) |-> div_ce);
endmodule

// File: rtl/sample_clk_divider.sv
`timescale 1ns/1ps
module sample_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 2,
  parameter logic [ADDR_W-1:0] SLIP_ADDR = 1,
  parameter int SLIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        strap,
  output logic              div_clk,
  output logic              div_ce
);
  logic [CODE_W-1:0] div_code;
  logic              slip_pend, slip_ack;
  div_sel_e          sel;

  clkdiv_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_ADDR(DIV_ADDR),
    .SLIP_ADDR(SLIP_ADDR), .SLIP_BIT(SLIP_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .slip_ack(slip_ack),
    .div_code(div_code), .slip_pend(slip_pend)
  );

  clkdiv_select u_sel (
    .div_code(div_code), .strap(strap), .sel(sel)
  );

  clkdiv_core u_core (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(sel),
    .slip_pend(slip_pend), .slip_ack(slip_ack),
    .div_clk(div_clk), .div_ce(div_ce)
  );
endmodule

// File: tb/sim_sample_clk_divider.sv
`timescale 1ns/1ps
module sim_sample_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] strap = 2'b01;
  logic       div_clk, div_ce;

  int errs = 0, checks = 0;
  logic ce_log [0:63];
  logic dc_log [0:63];
  int   pos [0:63];
  int   npos;

  always #4 clk = ~clk;

  sample_clk_divider u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .strap(strap),
    .div_clk(div_clk), .div_ce(div_ce)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // samples start at the current negedge; a pending write drops after one edge
  task automatic window(input int n);
    npos = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) wr_en = 1'b0;
      ce_log[i] = div_ce;
      dc_log[i] = div_clk;
      if (div_ce) begin pos[npos] = i; npos++; end
    end
  endtask

  task automatic sync_ce();
    do @(negedge clk); while (!div_ce);
  endtask

  // every complete gap equals n (or n-1 exactly once when a slip is expected)
  task automatic analyze(input int n, input string tag, input bit want_slip);
    int bad = 0, nslip = 0;
    for (int k = 1; k < npos; k++) begin
      int g = pos[k] - pos[k-1];
      if (want_slip && g == n - 1) nslip++;
      else if (g != n) bad++;
      else if (n >= 2)
        for (int j = pos[k-1]; j < pos[k]; j++)
          if (dc_log[j] != ((j - pos[k-1]) < n / 2)) bad++;
    end
    chk(bad == 0 && npos > 2, tag, bad, 0);
    if (want_slip) chk(nslip == 1, tag, nslip, 1);
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R9: counter held at zero in reset, strap control afterwards
    repeat (3) @(negedge clk);
    chk(div_ce == 1'b1, "R9 ce in reset", int'(div_ce), 1);
    rst_n = 1'b1;
    chk(div_ce == 1'b1, "R9 ce after release", int'(div_ce), 1);
    repeat (4) @(negedge clk);
    window(40); analyze(2, "R9 strap mid after reset", 0);

    // R3: strap sweep with field at 000
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      repeat (8) @(negedge clk);
      window(40);
      analyze((s == 1) ? 2 : (s == 2) ? 4 : 1, $sformatf("R3 strap=%0d", s), 0);
    end

    // R1 / R2: every field code, strap at mid (divide by 2)
    strap = 2'b01;
    for (int c = 0; c < 8; c++) begin
      int e;
      e = (c == 1) ? 1 : (c == 2) ? 2 : (c == 4) ? 4 : 2;
      wr(4'd2, 8'(c));
      repeat (8) @(negedge clk);
      window(40);
      analyze(e, (c == 1 || c == 2 || c == 4) ? $sformatf("R1 code=%0d", c)
                                              : $sformatf("R2 code=%0d", c), 0);
    end

    // R5 / R6: slip at divide by 2 and 4
    for (int k = 0; k < 2; k++) begin
      int n;
      n = (k == 0) ? 2 : 4;
      wr(4'd2, (k == 0) ? 8'h02 : 8'h04);
      repeat (8) @(negedge clk);
      sync_ce();
      wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h01;
      window(40); analyze(n, $sformatf("R5 slip n=%0d", n), 1);
      window(40); analyze(n, $sformatf("R6 after slip n=%0d", n), 0);
    end

    // R7: slip in undivided mode
    wr(4'd2, 8'h01);
    repeat (4) @(negedge clk);
    sync_ce();
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h01;
    window(20); analyze(1, "R7 slip div1", 0);

    // R4: 4 -> 2, current period completes at 4
    wr(4'd2, 8'h04);
    repeat (8) @(negedge clk);
    sync_ce();
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h02;
    window(12);
    chk(npos >= 3 && pos[1] - pos[0] == 4, "R4 4to2 first gap", pos[1] - pos[0], 4);
    chk(npos >= 3 && pos[2] - pos[1] == 2, "R4 4to2 next gap", pos[2] - pos[1], 2);
    // R4: 2 -> 4
    sync_ce();
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h04;
    window(14);
    chk(npos >= 3 && pos[1] - pos[0] == 2, "R4 2to4 first gap", pos[1] - pos[0], 2);
    chk(npos >= 3 && pos[2] - pos[1] == 4, "R4 2to4 next gap", pos[2] - pos[1], 4);

    // R8: soft reset mid-period keeps divide by 4 over strap mid
    repeat (5) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    window(40);
    chk(ce_log[0] == 1'b1, "R8 ce after soft reset", int'(ce_log[0]), 1);
    chk(dc_log[0] == 1'b1, "R8 div_clk after soft reset", int'(dc_log[0]), 1);
    analyze(4, "R8 divisor kept", 0);

    // R9: full reset clears field back to strap control
    wr(4'd2, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(div_ce == 1'b1, "R9 ce after full reset", int'(div_ce), 1);
    repeat (4) @(negedge clk);
    window(40); analyze(2, "R9 field cleared", 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule